// File: doc/BRIEF.md
# Watchdog Wake-Up Reset Sequencer

This block keeps time for a microcontroller that sleeps most of the time. It drives a wake-up line as a continuous square wave. Each rising edge asks the controller to wake, show that it is alive by pulling the watchdog input low, and then decide whether to go back to sleep. When the controller fails to produce a watchdog falling edge within a wake-up cycle, the block pulls its active-low reset output low for a short pulse. It then restarts the wake-up sequence after a fixed delay. A power-good flag, which reports that the supply is inside its regulation window, also holds the reset output low while it is deasserted.

All timings are whole multiples of one base unit. The base unit is a programmable number of clock cycles and stands in for a single timing element that sets every interval. One wake-up cycle is 8 units: 4 units high and 4 units low. A reset pulse lasts 1 unit. The gap from reset release to the first wake-up rising edge is 4 units. The watchdog input is asynchronous and passes through a two-stage synchronizer. The power-good flag is taken to be synchronous to the clock.

Top module: `wdr_wake_seq`

## Requirements
- R1: One base unit lasts `unit_div_i` clock cycles, and a divisor of 0 acts as 1. The base-unit counter is held cleared while reset is held for power, so every interval below is an exact multiple of the unit.
- R2: With no early acknowledge, the wake-up line rises at the start of each 8-unit cycle, falls after 4 units, and rises again 8 units after the previous rise.
- R3: The first falling edge on `wdi_i` in a cycle drives `wake_o` low on the third rising clock edge after `wdi_i` first reads low at a rising edge plus one. In other words, if `wdi_i` goes low between edges k and k+1, `wake_o` is low after edge k+3. It then stays low until the next cycle starts.
- R4: Further falling edges on `wdi_i` within the same cycle have no effect. The wake-up line stays low and the next cycle starts on time.
- R5: When a whole cycle passes without a detected watchdog edge, `rst_no` goes low at the cycle end for exactly 1 unit and `wake_o` is low.
- R6: A watchdog edge counts for a cycle only if its detection reaches the sequencer no later than the clock edge that ends the cycle. An edge detected later, while the reset pulse is running, is ignored.
- R7: A low `pwr_ok_i` sampled at a clock edge drives `rst_no` and `wake_o` low at that edge and holds them low. Once `pwr_ok_i` is sampled high, `rst_no` stays low for 1 more unit and then goes high.
- R8: While `rst_no` is low, `wake_o` is low. After `rst_no` rises, `wake_o` stays low for 4 units and then a fresh cycle begins with a rising edge.
- R9: Every restart clears the record of a seen watchdog edge, so the first cycle after a restart needs its own edge or it ends in a reset pulse.
- R10: While `arst_ni` is low, `rst_no` and `wake_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous reset, active low |
| wdi_i | input | 1 | Raw watchdog input from the controller; falling edges acknowledge a cycle |
| pwr_ok_i | input | 1 | Supply-in-regulation flag, synchronous to clk_i |
| unit_div_i | input | DIV_W | Base unit length in clock cycles (0 acts as 1) |
| wake_o | output | 1 | Wake-up square wave |
| rst_no | output | 1 | Reset output, active low |

## Verification
The hardest case to reach from the ports is a watchdog edge that lands right at the boundary of a cycle. There the synchronizer latency decides whether the edge acknowledges the ending cycle or arrives during the reset pulse and is discarded. The stimulus counts clock cycles from an observed wake-up rising edge and places falls at offsets 29 and 30 of a 32-cycle cycle, which straddles that boundary. A second case that is hard to reach is a seen edge that survives a restart. The stimulus reaches it by acknowledging a cycle, dropping power-good in the middle of that cycle, and then leaving the first restarted cycle unacknowledged.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

    typedef enum logic [1:0] {
        ST_POR_HOLD   = 2'd0,
        ST_RST_DELAY  = 2'd1,
        ST_WAKE_DELAY = 2'd2,
        ST_RUN        = 2'd3
    } wdr_state_e;

endpackage

// File: rtl/wdr_tick_div.sv
module wdr_tick_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             arst_ni,
    input  logic             clr_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim    = (div_i == '0) ? '0 : (div_i - DIV_W'(1));
        tick_o = !clr_i && (cnt_q >= lim);
        if (clr_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/wdr_fall_det.sv
module wdr_fall_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic arst_ni,
    input  logic wdi_i,
    output logic fall_o
);
    localparam int HIST_W = SYNC_STAGES + 1;

    logic [HIST_W-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = {hist_q[HIST_W-2:0], wdi_i};
        fall_o = hist_q[HIST_W-1] && !hist_q[HIST_W-2];
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            hist_q <= '1;
        end else begin
            hist_q <= hist_d;
        end
    end

endmodule

// File: rtl/wdr_seq_ctrl.sv
module wdr_seq_ctrl #(
    parameter int PERIOD_UNITS   = 8,
    parameter int RST_UNITS      = 1,
    parameter int WAKE_DLY_UNITS = 4
) (
    input  logic clk_i,
    input  logic arst_ni,
    input  logic tick_i,
    input  logic wdi_fall_i,
    input  logic pwr_ok_i,
    output logic wake_o,
    output logic rst_no,
    output logic div_clr_o
);
    import wdr_pkg::*;

    localparam int HALF_UNITS = PERIOD_UNITS / 2;
    localparam int MAX_A      = (PERIOD_UNITS > RST_UNITS) ? PERIOD_UNITS : RST_UNITS;
    localparam int MAX_U      = (MAX_A > WAKE_DLY_UNITS) ? MAX_A : WAKE_DLY_UNITS;
    localparam int UNIT_W     = (MAX_U > 1) ? $clog2(MAX_U) : 1;

    typedef struct packed {
        wdr_state_e        st;
        logic [UNIT_W-1:0] unit;
        logic              kicked;
        logic              wake;
        logic              rstn;
    } ctrl_s;

    ctrl_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_POR_HOLD: begin
                if (pwr_ok_i) begin
                    s_d.st   = ST_RST_DELAY;
                    s_d.unit = '0;
                end
            end
            ST_RST_DELAY: begin
                s_d.kicked = 1'b0;
                if (tick_i) begin
                    if (s_q.unit == UNIT_W'(RST_UNITS - 1)) begin
                        s_d.st   = ST_WAKE_DELAY;
                        s_d.unit = '0;
                    end else begin
                        s_d.unit = s_q.unit + UNIT_W'(1);
                    end
                end
            end
            ST_WAKE_DELAY: begin
                s_d.kicked = 1'b0;
                if (tick_i) begin
                    if (s_q.unit == UNIT_W'(WAKE_DLY_UNITS - 1)) begin
                        s_d.st   = ST_RUN;
                        s_d.unit = '0;
                    end else begin
                        s_d.unit = s_q.unit + UNIT_W'(1);
                    end
                end
            end
            ST_RUN: begin
                if (wdi_fall_i) begin
                    s_d.kicked = 1'b1;
                end
                if (tick_i) begin
                    if (s_q.unit == UNIT_W'(PERIOD_UNITS - 1)) begin
                        if (!s_d.kicked) begin
                            s_d.st = ST_RST_DELAY;
                        end
                        s_d.unit   = '0;
                        s_d.kicked = 1'b0;
                    end else begin
                        s_d.unit = s_q.unit + UNIT_W'(1);
                    end
                end
            end
            default: s_d.st = ST_POR_HOLD;
        endcase

        if (!pwr_ok_i) begin
            s_d.st     = ST_POR_HOLD;
            s_d.unit   = '0;
            s_d.kicked = 1'b0;
        end

        s_d.rstn = (s_d.st == ST_RUN) || (s_d.st == ST_WAKE_DELAY);
        s_d.wake = (s_d.st == ST_RUN) && !s_d.kicked && (32'(s_d.unit) < HALF_UNITS);
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            s_q <= '{st: ST_POR_HOLD, unit: '0, kicked: 1'b0, wake: 1'b0, rstn: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign wake_o    = s_q.wake;
    assign rst_no    = s_q.rstn;
    assign div_clr_o = (s_q.st == ST_POR_HOLD);

endmodule

// File: rtl/wdr_wake_seq.sv
module wdr_wake_seq #(
    parameter int DIV_W          = 16,
    parameter int PERIOD_UNITS   = 8,
    parameter int RST_UNITS      = 1,
    parameter int WAKE_DLY_UNITS = 4,
    parameter int SYNC_STAGES    = 2
) (
    input  logic             clk_i,
    input  logic             arst_ni,
    input  logic             wdi_i,
    input  logic             pwr_ok_i,
    input  logic [DIV_W-1:0] unit_div_i,
    output logic             wake_o,
    output logic             rst_no
);
    logic unit_tick;
    logic wdi_fall;
    logic div_clr;

    wdr_tick_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk_i   (clk_i),
        .arst_ni (arst_ni),
        .clr_i   (div_clr),
        .div_i   (unit_div_i),
        .tick_o  (unit_tick)
    );

    wdr_fall_det #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_fall (
        .clk_i   (clk_i),
        .arst_ni (arst_ni),
        .wdi_i   (wdi_i),
        .fall_o  (wdi_fall)
    );

    wdr_seq_ctrl #(
        .PERIOD_UNITS   (PERIOD_UNITS),
        .RST_UNITS      (RST_UNITS),
        .WAKE_DLY_UNITS (WAKE_DLY_UNITS)
    ) u_ctrl (
        .clk_i      (clk_i),
        .arst_ni    (arst_ni),
        .tick_i     (unit_tick),
        .wdi_fall_i (wdi_fall),
        .pwr_ok_i   (pwr_ok_i),
        .wake_o     (wake_o),
        .rst_no     (rst_no),
        .div_clr_o  (div_clr)
    );

endmodule

// File: rtl/wdr_wake_seq_chk.sv
module wdr_wake_seq_chk (
    input logic clk_i,
    input logic arst_ni,
    input logic pwr_ok_i,
    input logic tick,
    input logic wdi_fall,
    input logic wake_o,
    input logic rst_no
);
    // R7
    pwr_low_holds_reset_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        !pwr_ok_i |=> !rst_no);

    // R8
    wake_low_in_reset_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        !rst_no |-> !wake_o);

    // R1
    wake_rise_on_unit_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $rose(wake_o) |-> $past(tick));

    // R5
    reset_fall_cause_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $fell(rst_no) |-> (!$past(pwr_ok_i) || $past(tick)));

    // R7
    reset_release_on_unit_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $rose(rst_no) |-> $past(tick));

    // R3
    wake_fall_cause_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $fell(wake_o) |-> ($past(tick) || $past(wdi_fall) || !$past(pwr_ok_i)));

endmodule

bind wdr_wake_seq wdr_wake_seq_chk u_chk (
    .clk_i    (clk_i),
    .arst_ni  (arst_ni),
    .pwr_ok_i (pwr_ok_i),
    .tick     (unit_tick),
    .wdi_fall (wdi_fall),
    .wake_o   (wake_o),
    .rst_no   (rst_no)
);

// File: tb/wdr_wake_seq_bench.sv
module wdr_wake_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIVV       = 4;
    localparam int CYC        = 8 * DIVV;
    localparam int NVEC       = 8;

    // columns: first fall offset, second fall offset, expected wake fall offset, reset expected
    localparam int VEC [NVEC][4] = '{
        '{ 2, -1,  5, 0},   // R3 early acknowledge
        '{ 5,  9,  8, 0},   // R4 second edge ignored
        '{-1, -1, 16, 1},   // R5 missed cycle
        '{20, -1, 16, 0},   // R2 acknowledge in low half
        '{29, -1, 16, 0},   // R6 last edge that still counts
        '{30, -1, 16, 1},   // R6 edge detected during reset pulse
        '{12, -1, 15, 0},   // R3 just before half
        '{13, -1, 16, 0}    // R2 lands on half
    };

    logic        clk = 1'b0;
    logic        arst_n = 1'b0;
    logic        wdi = 1'b1;
    logic        pwr_ok = 1'b0;
    logic [15:0] div = 16'(DIVV);
    logic        wake, rst_n;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int t_wake_fall = -1;
    logic wake_prev = 1'b0;

    wdr_wake_seq u_wdr_wake_seq (
        .clk_i      (clk),
        .arst_ni    (arst_n),
        .wdi_i      (wdi),
        .pwr_ok_i   (pwr_ok),
        .unit_div_i (div),
        .wake_o     (wake),
        .rst_no     (rst_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (wake_prev && !wake) t_wake_fall = cyc;
        wake_prev = wake;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    function automatic string vec_tag(input int v);
        case (v)
            0: return "R3 vec0";
            1: return "R4 vec1";
            2: return "R5 vec2";
            3: return "R2 vec3";
            4: return "R6 vec4";
            5: return "R6 vec5";
            6: return "R3 vec6";
            default: return "R2 vec7";
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d (cycle %0d)", cyc, 0, cyc);
        summary();
        $finish;
    end

    initial begin
        int s;
        int s2;
        int c;
        @(negedge clk);
        // R10 reset state
        chk(rst_n == 1'b0, "R10 rst_n in reset", int'(rst_n), 0);
        chk(wake == 1'b0, "R10 wake in reset", int'(wake), 0);
        wait_cyc(2);
        arst_n = 1'b1;
        wait_cyc(4);
        chk(rst_n == 1'b0, "R7 rst_n while power low", int'(rst_n), 0);
        wait_cyc(5);
        pwr_ok = 1'b1;
        wait_cyc(9);
        chk(rst_n == 1'b0, "R7 rst_n before release", int'(rst_n), 0);
        wait_cyc(10);
        chk(rst_n == 1'b1, "R7 rst_n release", int'(rst_n), 1);
        wait_cyc(25);
        chk(wake == 1'b0, "R8 wake before delay end", int'(wake), 0);
        wait_cyc(26);
        chk(wake == 1'b1, "R8 wake first rise", int'(wake), 1);
        s = 26;

        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][0] >= 0) begin
                wait_cyc(s + VEC[v][0]);
                wdi = 1'b0;
                wait_cyc(s + VEC[v][0] + 2);
                wdi = 1'b1;
            end
            if (VEC[v][1] >= 0) begin
                wait_cyc(s + VEC[v][1]);
                wdi = 1'b0;
                wait_cyc(s + VEC[v][1] + 2);
                wdi = 1'b1;
            end
            wait_cyc(s + CYC - 1);
            chk(wake == 1'b0, {vec_tag(v), " wake low late in cycle"}, int'(wake), 0);
            wait_cyc(s + CYC);
            if (VEC[v][3] != 0) begin
                chk(rst_n == 1'b0, {vec_tag(v), " reset at cycle end"}, int'(rst_n), 0);
                chk(wake == 1'b0, {vec_tag(v), " wake during reset"}, int'(wake), 0);
            end else begin
                chk(rst_n == 1'b1, {vec_tag(v), " no reset at cycle end"}, int'(rst_n), 1);
                chk(wake == 1'b1, {vec_tag(v), " next cycle rise"}, int'(wake), 1);
            end
            wait_cyc(s + CYC + 1);
            chk(t_wake_fall == s + VEC[v][2], {vec_tag(v), " wake fall cycle"},
                t_wake_fall, s + VEC[v][2]);
            if (VEC[v][3] != 0) begin
                wait_cyc(s + CYC + DIVV - 1);
                chk(rst_n == 1'b0, "R5 pulse still low", int'(rst_n), 0);
                wait_cyc(s + CYC + DIVV);
                chk(rst_n == 1'b1, "R5 pulse width one unit", int'(rst_n), 1);
                wait_cyc(s + CYC + 5 * DIVV - 1);
                chk(wake == 1'b0, "R8 wake held after pulse", int'(wake), 0);
                wait_cyc(s + CYC + 5 * DIVV);
                chk(wake == 1'b1, "R8 wake restart rise", int'(wake), 1);
                s = s + CYC + 5 * DIVV;
            end else begin
                s = s + CYC;
            end
        end

        // R9: acknowledge, then power loss mid-cycle, then silent first cycle
        wait_cyc(s + 2);
        wdi = 1'b0;
        wait_cyc(s + 4);
        wdi = 1'b1;
        wait_cyc(s + 10);
        pwr_ok = 1'b0;
        wait_cyc(s + 11);
        chk(rst_n == 1'b0, "R7 power drop forces reset", int'(rst_n), 0);
        chk(wake == 1'b0, "R7 power drop forces wake low", int'(wake), 0);
        wait_cyc(s + 19);
        chk(rst_n == 1'b0, "R7 reset held while power low", int'(rst_n), 0);
        wait_cyc(s + 20);
        pwr_ok = 1'b1;
        wait_cyc(s + 24);
        chk(rst_n == 1'b0, "R7 release delay", int'(rst_n), 0);
        wait_cyc(s + 25);
        chk(rst_n == 1'b1, "R7 release after one unit", int'(rst_n), 1);
        wait_cyc(s + 41);
        chk(wake == 1'b1, "R8 restart rise after power", int'(wake), 1);
        s2 = s + 41;
        wait_cyc(s2 + CYC - 1);
        chk(rst_n == 1'b1, "R9 no reset before cycle end", int'(rst_n), 1);
        wait_cyc(s2 + CYC);
        chk(rst_n == 1'b0, "R9 stale acknowledge cleared", int'(rst_n), 0);
        wait_cyc(s2 + CYC + 5 * DIVV + 2);

        // R1: divisor 2
        c = cyc;
        div = 16'd2;
        pwr_ok = 1'b0;
        wait_cyc(c + 3);
        pwr_ok = 1'b1;
        wait_cyc(c + 5);
        chk(rst_n == 1'b0, "R1 div2 rst_n low", int'(rst_n), 0);
        wait_cyc(c + 6);
        chk(rst_n == 1'b1, "R1 div2 rst_n release", int'(rst_n), 1);
        wait_cyc(c + 13);
        chk(wake == 1'b0, "R1 div2 wake before rise", int'(wake), 0);
        wait_cyc(c + 14);
        chk(wake == 1'b1, "R1 div2 wake rise", int'(wake), 1);
        wait_cyc(c + 21);
        chk(wake == 1'b1, "R1 div2 wake high half", int'(wake), 1);
        wait_cyc(c + 22);
        chk(wake == 1'b0, "R1 div2 wake fall", int'(wake), 0);

        // R1: divisor 0 acts as 1
        c = cyc;
        div = 16'd0;
        pwr_ok = 1'b0;
        wait_cyc(c + 3);
        pwr_ok = 1'b1;
        wait_cyc(c + 4);
        chk(rst_n == 1'b0, "R1 div0 rst_n low", int'(rst_n), 0);
        wait_cyc(c + 5);
        chk(rst_n == 1'b1, "R1 div0 rst_n release", int'(rst_n), 1);
        wait_cyc(c + 8);
        chk(wake == 1'b0, "R1 div0 wake before rise", int'(wake), 0);
        wait_cyc(c + 9);
        chk(wake == 1'b1, "R1 div0 wake rise", int'(wake), 1);
        wait_cyc(c + 12);
        chk(wake == 1'b1, "R1 div0 wake high half", int'(wake), 1);
        wait_cyc(c + 13);
        chk(wake == 1'b0, "R1 div0 wake fall", int'(wake), 0);

        summary();
        $finish;
    end

endmodule